// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the two error counters that decide how much a CAN node may take part in bus traffic. The protocol engine sends it single-cycle strobes that are already classified: a minor receive error, a severe receive error, a transmit error, a frame received successfully and a frame sent successfully. From these strobes the block updates a 9-bit transmit counter and an 8-bit receive counter. From the counter values it derives whether the node is error-active, error-passive or bus-off.

The counters are visible in full width on dedicated outputs. They can also be read through a byte-wide read-only port whose one-bit select picks the low byte of the transmit counter or the receive counter. Bit timing, frame decoding, error classification and counting of idle sequences after bus-off are handled elsewhere. Software leaves bus-off by raising a recovery request.

Top module: `can_fault_conf`

## Requirements
- R1: While reset is held, and just after it is released, both counters read zero and the node reports error-active only.
- R2: A minor receive error adds 1 to the receive counter. A severe receive error adds 8. If both strobes are high together, only the severe increment of 8 applies. The receive counter saturates at 255 instead of wrapping.
- R3: A successful reception sets the receive counter to 120 if its value is above 128. At values from 1 to 128 it subtracts 1. At zero it leaves the counter at zero.
- R4: A transmit error adds 8 to the transmit counter. A successful transmission subtracts 1, and never takes the counter below zero.
- R5: When increment and decrement strobes arrive in the same cycle, the increment is applied first and the decrement is applied to that result. For example, a transmit error together with a successful transmission gives a net +7.
- R6: The state outputs are one-hot and registered one cycle behind the counters. Bus-off is reported when the transmit counter exceeds 255. Otherwise error-passive is reported when either counter exceeds 127. Otherwise error-active is reported.
- R7: While the transmit counter exceeds 255, every error and success strobe is ignored, and both counters hold their values.
- R8: A recovery request while the transmit counter exceeds 255 clears both counters to zero on the next edge. At any other time the request has no effect on either counter.
- R9: The byte read port returns the transmit counter's bits 7:0 when the select is 0 and the receive counter when the select is 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_err_minor | input | 1 | Receive error strobe, weight 1 |
| rx_err_severe | input | 1 | Receive error strobe, weight 8 |
| tx_err | input | 1 | Transmit error strobe, weight 8 |
| rx_done | input | 1 | Successful reception strobe |
| tx_done | input | 1 | Successful transmission strobe |
| recover_req | input | 1 | Software bus-off recovery request |
| rd_sel | input | 1 | Byte port select: 0 transmit, 1 receive |
| rd_data | output | 8 | Byte read data |
| tec_count | output | 9 | Transmit error counter |
| rec_count | output | 8 | Receive error counter |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
A strobe that is valid before a clock edge changes the counters right after that edge. The three state outputs change one edge later, and the byte port follows the counters with no delay. The bench keeps a model of both counters that it updates at every edge. It compares counters and byte port a short time after the edge. It compares the state outputs against the model values from before that edge, which is the one-cycle lag. Sweeps take the receive counter through every value from 0 to 255 and the transmit counter through every value from 0 to 255, apply each strobe combination at each value, and then run a pseudo-random phase.

// File: rtl/fc_pkg.sv
package fc_pkg;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_mode_e;

   typedef struct packed {
      logic minor;
      logic severe;
      logic done;
   } fc_rx_ev_t;

   typedef struct packed {
      logic err;
      logic done;
   } fc_tx_ev_t;

endpackage

// File: rtl/fc_rx_counter.sv
module fc_rx_counter
   import fc_pkg::*;
#(
   parameter int unsigned REC_W      = 8,
   parameter int unsigned MINOR_INC  = 1,
   parameter int unsigned SEVERE_INC = 8,
   parameter int unsigned SNAP_ABOVE = 128,
   parameter int unsigned SNAP_TO    = 120,
   parameter bit          SATURATE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fc_rx_ev_t        ev,
   input  logic             freeze,
   input  logic             clear,
   output logic [REC_W-1:0] rec_q
);

   localparam logic [REC_W:0]   INC_MINOR  = (REC_W+1)'(MINOR_INC);
   localparam logic [REC_W:0]   INC_SEVERE = (REC_W+1)'(SEVERE_INC);
   localparam logic [REC_W-1:0] SNAP_HI    = REC_W'(SNAP_ABOVE);
   localparam logic [REC_W-1:0] SNAP_LO    = REC_W'(SNAP_TO);

   if (SNAP_TO > SNAP_ABOVE) begin : g_bad_snap
      $error("fc_rx_counter: snap target above snap threshold");
   end
   if (SNAP_ABOVE >= (1 << REC_W)) begin : g_bad_width
      $error("fc_rx_counter: snap threshold does not fit counter");
   end
   if (SEVERE_INC < MINOR_INC || SEVERE_INC >= (1 << REC_W)) begin : g_bad_inc
      $error("fc_rx_counter: increment weights out of range");
   end

   logic [REC_W:0]   inc_w;
   logic [REC_W:0]   sum_w;
   logic [REC_W-1:0] after_inc;
   logic [REC_W-1:0] after_dec;
   logic [REC_W-1:0] rec_d;

   always_comb begin
      if (ev.severe)     inc_w = INC_SEVERE;
      else if (ev.minor) inc_w = INC_MINOR;
      else               inc_w = '0;
      sum_w = {1'b0, rec_q} + inc_w;
   end

   if (SATURATE) begin : g_sat
      always_comb after_inc = sum_w[REC_W] ? '1 : sum_w[REC_W-1:0];

      property p_rec_sat;
         @(posedge clk) disable iff (!rst_n)
            (rec_q == '1 && (ev.minor || ev.severe) && !ev.done && !freeze && !clear)
            |=> (rec_q == '1);
      endproperty
      AST_REC_SATURATE: assert property (p_rec_sat); // R2
   end else begin : g_wrap
      always_comb after_inc = sum_w[REC_W-1:0];
   end

   always_comb begin
      after_dec = after_inc;
      if (ev.done) begin
         if (after_inc > SNAP_HI)     after_dec = SNAP_LO;
         else if (after_inc != '0)    after_dec = after_inc - 1'b1;
      end
   end

   always_comb begin
      if (clear)       rec_d = '0;
      else if (freeze) rec_d = rec_q;
      else             rec_d = after_dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_q <= '0;
      else        rec_q <= rec_d;
   end

   property p_rec_snap;
      @(posedge clk) disable iff (!rst_n)
         (!freeze && !clear && ev.done && !ev.minor && !ev.severe && rec_q > SNAP_HI)
         |=> (rec_q == SNAP_LO);
   endproperty
   AST_REC_SNAP: assert property (p_rec_snap); // R3

   property p_rec_floor;
      @(posedge clk) disable iff (!rst_n)
         (!freeze && !clear && ev.done && !ev.minor && !ev.severe && rec_q == '0)
         |=> (rec_q == '0);
   endproperty
   AST_REC_NO_UNDERFLOW: assert property (p_rec_floor); // R3

   property p_rec_frozen;
      @(posedge clk) disable iff (!rst_n)
         (freeze && !clear) |=> $stable(rec_q);
   endproperty
   AST_REC_FROZEN: assert property (p_rec_frozen); // R7

endmodule

// File: rtl/fc_tx_counter.sv
module fc_tx_counter
   import fc_pkg::*;
#(
   parameter int unsigned TEC_W  = 9,
   parameter int unsigned TX_INC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fc_tx_ev_t        ev,
   input  logic             recover_req,
   output logic [TEC_W-1:0] tec_q,
   output logic             frozen,
   output logic             clear_all
);

   localparam int unsigned      LIM_I = (1 << (TEC_W - 1)) - 1;
   localparam logic [TEC_W-1:0] LIM   = TEC_W'(LIM_I);
   localparam logic [TEC_W-1:0] INC   = TEC_W'(TX_INC);

   if (TEC_W < 2) begin : g_bad_width
      $error("fc_tx_counter: counter too narrow");
   end
   if (TX_INC < 1 || TX_INC > LIM_I + 1) begin : g_bad_inc
      $error("fc_tx_counter: increment could wrap the counter");
   end

   logic [TEC_W-1:0] after_inc;
   logic [TEC_W-1:0] tec_d;

   assign frozen    = (tec_q > LIM);
   assign clear_all = frozen && recover_req;

   always_comb begin
      after_inc = tec_q + (ev.err ? INC : '0);
      if (frozen) begin
         tec_d = clear_all ? '0 : tec_q;
      end else if (ev.done && after_inc != '0) begin
         tec_d = after_inc - 1'b1;
      end else begin
         tec_d = after_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tec_q <= '0;
      else        tec_q <= tec_d;
   end

   property p_tec_floor;
      @(posedge clk) disable iff (!rst_n)
         (tec_q == '0 && ev.done && !ev.err) |=> (tec_q == '0);
   endproperty
   AST_TEC_FLOOR: assert property (p_tec_floor); // R4

   property p_tec_net;
      @(posedge clk) disable iff (!rst_n)
         (!frozen && ev.err && ev.done) |=> (tec_q == $past(tec_q) + INC - 1'b1);
   endproperty
   AST_TEC_NET_ORDER: assert property (p_tec_net); // R5

   property p_tec_frozen;
      @(posedge clk) disable iff (!rst_n)
         (frozen && !recover_req) |=> $stable(tec_q);
   endproperty
   AST_TEC_FROZEN: assert property (p_tec_frozen); // R7

   property p_recover;
      @(posedge clk) disable iff (!rst_n)
         (frozen && recover_req) |=> (tec_q == '0);
   endproperty
   AST_RECOVER_CLEARS: assert property (p_recover); // R8

endmodule

// File: rtl/fc_state.sv
module fc_state
   import fc_pkg::*;
#(
   parameter int unsigned TEC_W       = 9,
   parameter int unsigned REC_W       = 8,
   parameter int unsigned PASSIVE_LIM = 127
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TEC_W-1:0] tec_q,
   input  logic [REC_W-1:0] rec_q,
   output logic             err_active,
   output logic             err_passive,
   output logic             bus_off
);

   localparam int unsigned      BUS_I  = (1 << (TEC_W - 1)) - 1;
   localparam logic [TEC_W-1:0] BUS_T  = TEC_W'(BUS_I);
   localparam logic [TEC_W-1:0] PASS_T = TEC_W'(PASSIVE_LIM);
   localparam logic [REC_W:0]   PASS_R = (REC_W+1)'(PASSIVE_LIM);

   if (PASSIVE_LIM >= BUS_I) begin : g_bad_lim
      $error("fc_state: passive limit must lie below bus-off limit");
   end

   fc_mode_e mode_d, mode_q;

   always_comb begin
      if (tec_q > BUS_T)                                  mode_d = FC_BUSOFF;
      else if (tec_q > PASS_T || {1'b0, rec_q} > PASS_R)  mode_d = FC_PASSIVE;
      else                                                mode_d = FC_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= FC_ACTIVE;
      else        mode_q <= mode_d;
   end

   assign err_active  = (mode_q == FC_ACTIVE);
   assign err_passive = (mode_q == FC_PASSIVE);
   assign bus_off     = (mode_q == FC_BUSOFF);

   property p_busoff_lag;
      @(posedge clk) disable iff (!rst_n)
         (tec_q > BUS_T) |=> bus_off;
   endproperty
   AST_BUSOFF_LAG: assert property (p_busoff_lag); // R6

   property p_active_lag;
      @(posedge clk) disable iff (!rst_n)
         (tec_q <= PASS_T && {1'b0, rec_q} <= PASS_R) |=> err_active;
   endproperty
   AST_ACTIVE_LAG: assert property (p_active_lag); // R6

endmodule

// File: rtl/fc_regport.sv
module fc_regport #(
   parameter int unsigned TEC_W  = 9,
   parameter int unsigned REC_W  = 8,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              rd_sel,
   input  logic [TEC_W-1:0]  tec_q,
   input  logic [REC_W-1:0]  rec_q,
   output logic [BYTE_W-1:0] rd_data
);

   logic [BYTE_W-1:0] tec_b;
   logic [BYTE_W-1:0] rec_b;

   if (TEC_W >= BYTE_W) begin : g_tec_slice
      assign tec_b = tec_q[BYTE_W-1:0];
   end else begin : g_tec_pad
      assign tec_b = {{(BYTE_W-TEC_W){1'b0}}, tec_q};
   end

   if (REC_W >= BYTE_W) begin : g_rec_slice
      assign rec_b = rec_q[BYTE_W-1:0];
   end else begin : g_rec_pad
      assign rec_b = {{(BYTE_W-REC_W){1'b0}}, rec_q};
   end

   assign rd_data = rd_sel ? rec_b : tec_b;

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import fc_pkg::*;
#(
   parameter int unsigned TEC_W       = 9,
   parameter int unsigned REC_W       = 8,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned MINOR_INC   = 1,
   parameter int unsigned SEVERE_INC  = 8,
   parameter int unsigned TX_INC      = 8,
   parameter int unsigned SNAP_ABOVE  = 128,
   parameter int unsigned SNAP_TO     = 120,
   parameter int unsigned PASSIVE_LIM = 127,
   parameter bit          RX_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_err_minor,
   input  logic              rx_err_severe,
   input  logic              tx_err,
   input  logic              rx_done,
   input  logic              tx_done,
   input  logic              recover_req,
   input  logic              rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   output logic [TEC_W-1:0]  tec_count,
   output logic [REC_W-1:0]  rec_count,
   output logic              err_active,
   output logic              err_passive,
   output logic              bus_off
);

   fc_rx_ev_t rx_ev;
   fc_tx_ev_t tx_ev;
   logic      frozen;
   logic      clear_all;

   assign rx_ev = '{minor: rx_err_minor, severe: rx_err_severe, done: rx_done};
   assign tx_ev = '{err: tx_err, done: tx_done};

   fc_tx_counter #(
      .TEC_W  (TEC_W),
      .TX_INC (TX_INC)
   ) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (tx_ev),
      .recover_req (recover_req),
      .tec_q       (tec_count),
      .frozen      (frozen),
      .clear_all   (clear_all)
   );

   fc_rx_counter #(
      .REC_W      (REC_W),
      .MINOR_INC  (MINOR_INC),
      .SEVERE_INC (SEVERE_INC),
      .SNAP_ABOVE (SNAP_ABOVE),
      .SNAP_TO    (SNAP_TO),
      .SATURATE   (RX_SATURATE)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (rx_ev),
      .freeze (frozen),
      .clear  (clear_all),
      .rec_q  (rec_count)
   );

   fc_state #(
      .TEC_W       (TEC_W),
      .REC_W       (REC_W),
      .PASSIVE_LIM (PASSIVE_LIM)
   ) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .tec_q       (tec_count),
      .rec_q       (rec_count),
      .err_active  (err_active),
      .err_passive (err_passive),
      .bus_off     (bus_off)
   );

   fc_regport #(
      .TEC_W  (TEC_W),
      .REC_W  (REC_W),
      .BYTE_W (BYTE_W)
   ) u_regport (
      .rd_sel  (rd_sel),
      .tec_q   (tec_count),
      .rec_q   (rec_count),
      .rd_data (rd_data)
   );

endmodule

// File: tb/can_fault_conf_bench.sv
`timescale 1ns/100ps
module can_fault_conf_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_err_minor = 1'b0, rx_err_severe = 1'b0, tx_err = 1'b0;
   logic       rx_done = 1'b0, tx_done = 1'b0, recover_req = 1'b0, rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic [8:0] tec_count;
   logic [7:0] rec_count;
   logic       err_active, err_passive, bus_off;

   int n_chk  = 0;
   int n_fail = 0;
   int m_tec  = 0;
   int m_rec  = 0;
   bit done_run = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_5EED;

   always #2.5 clk = ~clk;

   can_fault_conf u_can_fault_conf (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_err_minor  (rx_err_minor),
      .rx_err_severe (rx_err_severe),
      .tx_err        (tx_err),
      .rx_done       (rx_done),
      .tx_done       (tx_done),
      .recover_req   (recover_req),
      .rd_sel        (rd_sel),
      .rd_data       (rd_data),
      .tec_count     (tec_count),
      .rec_count     (rec_count),
      .err_active    (err_active),
      .err_passive   (err_passive),
      .bus_off       (bus_off)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int next_rec(int r, bit mn, bit sv, bit ok);
      int s;
      s = r + (sv ? 8 : (mn ? 1 : 0));
      if (s > 255) s = 255;
      if (ok) begin
         if (s > 128)    s = 120;
         else if (s > 0) s = s - 1;
      end
      return s;
   endfunction

   function automatic int next_tec(int t, bit te, bit ok);
      int s;
      s = t + (te ? 8 : 0);
      if (ok && s > 0) s = s - 1;
      return s;
   endfunction

   task automatic check_ports(input int exp_a, input int exp_p, input int exp_b,
                              input string rtag, input string ttag);
      chk(ttag, "tec_count", int'(tec_count), m_tec);
      chk(rtag, "rec_count", int'(rec_count), m_rec);
      chk("R6", "err_active", int'(err_active), exp_a);
      chk("R6", "err_passive", int'(err_passive), exp_p);
      chk("R6", "bus_off", int'(bus_off), exp_b);
      rd_sel = 1'b0;
      #0.2;
      chk("R9", "rd_data tec", int'(rd_data), m_tec % 256);
      rd_sel = 1'b1;
      #0.2;
      chk("R9", "rd_data rec", int'(rd_data), m_rec);
   endtask

   task automatic cyc(input bit mn, input bit sv, input bit te,
                      input bit ro, input bit to, input bit rv);
      int ea, ep, eb;
      string rtag, ttag;
      @(negedge clk);
      rx_err_minor = mn; rx_err_severe = sv; tx_err = te;
      rx_done = ro; tx_done = to; recover_req = rv;
      @(posedge clk);
      // state lags: derived from counters held before this edge (R6)
      eb = (m_tec > 255) ? 1 : 0;
      ep = (!eb && (m_tec > 127 || m_rec > 127)) ? 1 : 0;
      ea = (!eb && !ep) ? 1 : 0;
      if (m_tec > 255) begin
         rtag = rv ? "R8" : "R7";
         ttag = rtag;
         if (rv) begin m_tec = 0; m_rec = 0; end
      end else begin
         if ((mn || sv) && ro) rtag = "R5";
         else if (mn || sv)    rtag = "R2";
         else if (ro)          rtag = "R3";
         else                  rtag = rv ? "R8" : "R2";
         if (te && to)         ttag = "R5";
         else                  ttag = rv ? "R8" : "R4";
         m_rec = next_rec(m_rec, mn, sv, ro);
         m_tec = next_tec(m_tec, te, to);
      end
      #1;
      check_ports(ea, ep, eb, rtag, ttag);
   endtask

   task automatic clear_all_ctr();
      while (m_tec <= 255) cyc(0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1);
   endtask

   task automatic reach_rec(input int v);
      while (m_rec + 8 <= v) cyc(0, 1, 0, 0, 0, 0);
      while (m_rec < v)      cyc(1, 0, 0, 0, 0, 0);
   endtask

   task automatic reach_tec(input int t);
      while (m_tec < t) begin
         if (m_tec + 8 <= 255) cyc(0, 0, 1, 0, 0, 0);
         else                  cyc(0, 0, 1, 0, 1, 0);
      end
      while (m_tec > t) cyc(0, 0, 0, 0, 1, 0);
   endtask

   initial begin
      repeat (200000 - 5000) @(posedge clk);
      if (!done_run) begin
         n_fail++;
         n_chk++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values while reset is held
      chk("R1", "tec_count in reset", int'(tec_count), 0);
      chk("R1", "rec_count in reset", int'(rec_count), 0);
      chk("R1", "err_active in reset", int'(err_active), 1);
      chk("R1", "err_passive in reset", int'(err_passive), 0);
      chk("R1", "bus_off in reset", int'(bus_off), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0, 0);

      // R2 R3 R5 sweep over every receive counter value
      for (int v = 0; v < 256; v++) begin
         for (int op = 0; op < 4; op++) begin
            clear_all_ctr();
            reach_rec(v);
            case (op)
               0: cyc(1, 0, 0, 0, 0, 0);
               1: cyc(0, 1, 0, 0, 0, 0);
               2: cyc(0, 0, 0, 1, 0, 0);
               default: cyc(1, 1, 0, 1, 0, 0);
            endcase
         end
      end

      // R4 R5 R7 sweep over every transmit counter value below bus-off
      for (int t = 0; t < 256; t++) begin
         for (int op = 0; op < 3; op++) begin
            clear_all_ctr();
            reach_tec(t);
            case (op)
               0: cyc(0, 0, 1, 0, 0, 0);
               1: cyc(0, 0, 0, 0, 1, 0);
               default: cyc(0, 0, 1, 0, 1, 0);
            endcase
            if (m_tec > 255) cyc(1, 1, 1, 1, 1, 0); // R7: all strobes ignored
         end
      end

      // R8: recovery request outside bus-off has no effect
      clear_all_ctr();
      reach_tec(100);
      reach_rec(50);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R8", "tec unchanged by recovery", int'(tec_count), 100);
      chk("R8", "rec unchanged by recovery", int'(rec_count), 50);

      // pseudo-random mix of all strobes
      for (int i = 0; i < 4000; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         cyc(lfsr[0] & lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], lfsr[5] & lfsr[6],
             lfsr[7] | lfsr[8], lfsr[9] | lfsr[10], lfsr[11] & lfsr[12] & lfsr[13]);
      end

      done_run = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule